// File: doc/BRIEF.md
# Indirect Flash Window Register Target

This block is a register target that lets a host reach a small flash array only indirectly. The host first writes a byte address into an address register, and then reads or writes the data window register. The window access moves a 32-bit or 64-bit value at the latched address, inside the partition chosen by a region-select register. Every address is relative to the start of the selected region. A behavioural word array stands in for the flash.

An erase-command register starts a 4 KiB block wipe. The command word carries a size code and a region number. The block is the one that contains the latched address. Completion is reported by a done flag in a second register space, and the host clears that flag by writing it back. Faults are recorded in a sticky error register that is cleared by writing ones, and the latched address of the last faulting access is kept in a separate register.

Requests enter on a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Every accepted read returns exactly one response on a valid/ready channel in the following cycle. While a response is waiting with `rsp_ready` low, the response holds its data and `req_ready` stays low, so no new request can be taken. Writes produce no response.

Top module: `flashwin_target`

## Requirements
- R1: After reset the region select reads 0, the error register reads 0, the done flag reads 0, `req_ready` is high and `rsp_valid` is low.
- R2: A 32-bit window write (space 0, offset 0x00) stores data at the latched address (offset 0x40) of the selected region (offset 0x44). A later 32-bit window read there returns the same word in `rsp_rdata[31:0]`, with the upper half zero.
- R3: A 64-bit window access needs only 4-byte alignment. Bits [31:0] map to the latched address and bits [63:32] map to the address plus 4.
- R4: A window access is out of bounds when the region is 2 or higher, the address is 8192 or higher, or the access is 64-bit and the address is above 8184. Such an access sets error bit 0, leaves the array unchanged and reads back 0.
- R5: A 64-bit access whose address modulo 1024 is 1020 crosses a 1 KiB line. It sets error bit 1, leaves the array unchanged and reads back 0.
- R6: A window access with address bits [1:0] not zero sets error bit 2 and has no effect.
- R7: The error register (offset 0x70) holds three bits that stay set until a write of ones to them. Written zeros and bits above bit 2 change nothing.
- R8: After any faulting window or erase access, offset 0x74 reads the latched address that access used.
- R9: Writing an erase word to offset 0x48 starts an erase when bits [15:0] are 0x0010 and bits [31:24] name a region below 2. The erase sets every word of the 4 KiB block containing the latched address to 0xFFFFFFFF and leaves all other words unchanged.
- R10: Bit 23 of space-1 offset 0x00 is the done flag. It is low for the 1040 busy cycles of an erase and rises once the erase ends. A space-1 write with bit 23 set clears it; a write with bit 23 clear leaves it set.
- R11: An erase word with another size code sets error bit 2. An erase word with a region of 2 or higher, or a latched address of 8192 or higher, sets error bit 0. In both cases no erase starts.
- R12: While an erase is busy, window accesses and erase words set error bit 2 and are ignored.
- R13: A read response holds `rsp_valid` and `rsp_rdata` steady while `rsp_ready` is low, and `req_ready` is low during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 1 | 0 = main registers, 1 = status space |
| req_wide | input | 1 | Window access is 64-bit |
| req_offset | input | 8 | Register byte offset |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 64 | Read response data |

## Verification
The hardest states to reach are those where a window access lands during a running erase, and where the partial-clear rule of the sticky error bits meets several faults at once. The stimulus reaches the first by issuing a window write right after the erase word, while the done flag still reads low. It then shows that the targeted word is unchanged once the erase ends. For the second, the bench raises range and alignment faults with separate accesses and then clears one bit at a time. Boundary addresses are placed directly: 1016 and 1020 for the 1 KiB line, and 8184, 8188 and 8192 for the region end. These are mixed with seeded random window traffic checked against a bench-side word model.

// File: rtl/flashwin_pkg.sv
package flashwin_pkg;
  localparam logic [7:0] OFF_WINDOW  = 8'h00;
  localparam logic [7:0] OFF_ADDR    = 8'h40;
  localparam logic [7:0] OFF_REGION  = 8'h44;
  localparam logic [7:0] OFF_ERASE   = 8'h48;
  localparam logic [7:0] OFF_ERR     = 8'h70;
  localparam logic [7:0] OFF_ERRADDR = 8'h74;
  localparam logic [7:0] OFF_STATUS  = 8'h00;

  localparam int ERR_RANGE = 0;
  localparam int ERR_CROSS = 1;
  localparam int ERR_BAD   = 2;
  localparam int ERR_W     = 3;

  localparam logic [15:0] ERASE_4K = 16'h0010;
  localparam int DONE_BIT = 23;

  typedef enum logic [1:0] {ER_IDLE, ER_WIPE, ER_HOLD} erase_state_e;
endpackage

// File: rtl/flashwin_check.sv
module flashwin_check
  import flashwin_pkg::*;
#(
  parameter int NUM_REGIONS  = 2,
  parameter int REGION_BYTES = 8192
) (
  input  logic [31:0]      addr,
  input  logic [7:0]       region,
  input  logic             wide,
  output logic [ERR_W-1:0] err
);
  localparam logic [32:0] LAST_NARROW = 33'(REGION_BYTES - 4);
  localparam logic [32:0] LAST_WIDE   = 33'(REGION_BYTES - 8);

  logic past_end;

  always_comb begin
    past_end = wide ? ({1'b0, addr} > LAST_WIDE) : ({1'b0, addr} > LAST_NARROW);
    err = '0;
    err[ERR_BAD]   = (addr[1:0] != 2'b00);
    err[ERR_RANGE] = (32'(region) >= 32'(NUM_REGIONS)) || past_end;
    err[ERR_CROSS] = wide && (addr[9:2] == 8'hFF);
  end
endmodule

// File: rtl/flashwin_array.sv
module flashwin_array #(
  parameter int WORDS = 4096,
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [IDX_W-1:0] idx_lo,
  input  logic [IDX_W-1:0] idx_hi,
  input  logic [31:0]      wd_lo,
  input  logic [31:0]      wd_hi,
  input  logic             wipe_en,
  input  logic [IDX_W-1:0] wipe_idx,
  output logic [31:0]      rd_lo,
  output logic [31:0]      rd_hi
);
  logic [31:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (wipe_en) cells[wipe_idx] <= '1;
    if (wr_lo)   cells[idx_lo]   <= wd_lo;
    if (wr_hi)   cells[idx_hi]   <= wd_hi;
  end

  assign rd_lo = cells[idx_lo];
  assign rd_hi = cells[idx_hi];
endmodule

// File: rtl/flashwin_eraser.sv
module flashwin_eraser
  import flashwin_pkg::*;
#(
  parameter int BLOCK_WORDS = 1024,
  parameter int HOLD_CYCLES = 16,
  parameter int IDX_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] base_idx,
  output logic             busy,
  output logic             finish,
  output logic             wipe_en,
  output logic [IDX_W-1:0] wipe_idx
);
  localparam int SPAN  = (BLOCK_WORDS > HOLD_CYCLES) ? BLOCK_WORDS : HOLD_CYCLES;
  localparam int CNT_W = (SPAN > 1) ? $clog2(SPAN) : 1;
  localparam logic [CNT_W-1:0] WIPE_LAST = CNT_W'(BLOCK_WORDS - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);

  erase_state_e     state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ER_IDLE;
      cnt    <= '0;
      base_q <= '0;
    end else begin
      case (state)
        ER_IDLE: if (start) begin
          state  <= ER_WIPE;
          cnt    <= '0;
          base_q <= base_idx;
        end
        ER_WIPE: if (cnt == WIPE_LAST) begin
          state <= ER_HOLD;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        ER_HOLD: if (cnt == HOLD_LAST) begin
          state <= ER_IDLE;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= ER_IDLE;
      endcase
    end
  end

  assign busy     = (state != ER_IDLE);
  assign wipe_en  = (state == ER_WIPE);
  assign wipe_idx = base_q + IDX_W'(cnt);
  assign finish   = (state == ER_HOLD) && (cnt == HOLD_LAST);
endmodule

// File: rtl/flashwin_target.sv
module flashwin_target
  import flashwin_pkg::*;
#(
  parameter int NUM_REGIONS  = 2,
  parameter int REGION_BYTES = 8192,
  parameter int BLOCK_BYTES  = 4096,
  parameter int ERASE_HOLD   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_space,
  input  logic        req_wide,
  input  logic [7:0]  req_offset,
  input  logic [63:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [63:0] rsp_rdata
);
  localparam int REGION_WORDS = REGION_BYTES / 4;
  localparam int BLOCK_WORDS  = BLOCK_BYTES / 4;
  localparam int RSEL_W       = $clog2(NUM_REGIONS);
  localparam int RW_W         = $clog2(REGION_WORDS);
  localparam int BW_W         = $clog2(BLOCK_WORDS);
  localparam int IDX_W        = RSEL_W + RW_W;
  localparam int WORDS        = NUM_REGIONS * REGION_WORDS;

  logic [31:0]      addr_q;
  logic [7:0]       region_q;
  logic [ERR_W-1:0] err_q;
  logic [31:0]      addr_err_q;
  logic             done_q;

  logic accept, main_wr, main_rd, stat_wr;
  logic hit_window, hit_erase, window_ok, erase_go;
  logic [ERR_W-1:0] chk_err, window_err, erase_err, new_err, err_clr;
  logic busy, finish, wipe_en;
  logic [IDX_W-1:0] wipe_idx, idx_lo, idx_hi, erase_base;
  logic [31:0] rd_lo, rd_hi;
  logic [63:0] read_mux;
  logic [15:0] erase_code;
  logic [7:0]  erase_region;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign main_wr   = accept && !req_space && req_write;
  assign main_rd   = accept && !req_space && !req_write;
  assign stat_wr   = accept && req_space && req_write && (req_offset == OFF_STATUS);

  flashwin_check #(
    .NUM_REGIONS(NUM_REGIONS),
    .REGION_BYTES(REGION_BYTES)
  ) u_check (
    .addr(addr_q),
    .region(region_q),
    .wide(req_wide),
    .err(chk_err)
  );

  assign hit_window = accept && !req_space && (req_offset == OFF_WINDOW);
  always_comb begin
    window_err = chk_err;
    if (busy) window_err[ERR_BAD] = 1'b1;
  end
  assign window_ok = hit_window && (window_err == '0);

  assign idx_lo = {region_q[RSEL_W-1:0], addr_q[RW_W+1:2]};
  assign idx_hi = idx_lo + 1'b1;

  assign erase_code   = req_wdata[15:0];
  assign erase_region = req_wdata[31:24];
  assign hit_erase    = main_wr && (req_offset == OFF_ERASE);
  always_comb begin
    erase_err = '0;
    erase_err[ERR_BAD]   = (erase_code != ERASE_4K) || busy;
    erase_err[ERR_RANGE] = (32'(erase_region) >= 32'(NUM_REGIONS)) ||
                           (addr_q >= 32'(REGION_BYTES));
  end
  assign erase_go   = hit_erase && (erase_err == '0);
  assign erase_base = {erase_region[RSEL_W-1:0], addr_q[RW_W+1:BW_W+2], BW_W'(0)};

  flashwin_array #(
    .WORDS(WORDS),
    .IDX_W(IDX_W)
  ) u_array (
    .clk(clk),
    .wr_lo(window_ok && req_write),
    .wr_hi(window_ok && req_write && req_wide),
    .idx_lo(idx_lo),
    .idx_hi(idx_hi),
    .wd_lo(req_wdata[31:0]),
    .wd_hi(req_wdata[63:32]),
    .wipe_en(wipe_en),
    .wipe_idx(wipe_idx),
    .rd_lo(rd_lo),
    .rd_hi(rd_hi)
  );

  flashwin_eraser #(
    .BLOCK_WORDS(BLOCK_WORDS),
    .HOLD_CYCLES(ERASE_HOLD),
    .IDX_W(IDX_W)
  ) u_eraser (
    .clk(clk),
    .rst_n(rst_n),
    .start(erase_go),
    .base_idx(erase_base),
    .busy(busy),
    .finish(finish),
    .wipe_en(wipe_en),
    .wipe_idx(wipe_idx)
  );

  always_comb begin
    new_err = '0;
    if (hit_window)     new_err = window_err;
    else if (hit_erase) new_err = erase_err;
    err_clr = (main_wr && (req_offset == OFF_ERR)) ? req_wdata[ERR_W-1:0] : '0;
  end

  for (genvar b = 0; b < ERR_W; b++) begin : g_err
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q[b] <= 1'b0;
      else        err_q[b] <= new_err[b] | (err_q[b] & ~err_clr[b]);
    end
  end

  always_comb begin
    read_mux = '0;
    if (req_space) begin
      if (req_offset == OFF_STATUS) read_mux[DONE_BIT] = done_q;
    end else begin
      case (req_offset)
        OFF_WINDOW:  if (window_ok) read_mux = req_wide ? {rd_hi, rd_lo} : {32'h0, rd_lo};
        OFF_ADDR:    read_mux = {32'h0, addr_q};
        OFF_REGION:  read_mux = {56'h0, region_q};
        OFF_ERR:     read_mux = {{(64-ERR_W){1'b0}}, err_q};
        OFF_ERRADDR: read_mux = {32'h0, addr_err_q};
        default:     read_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      region_q   <= '0;
      addr_err_q <= '0;
      done_q     <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      if (main_wr && (req_offset == OFF_ADDR))   addr_q   <= req_wdata[31:0];
      if (main_wr && (req_offset == OFF_REGION)) region_q <= req_wdata[7:0];
      if (new_err != '0) addr_err_q <= addr_q;
      if (finish)                          done_q <= 1'b1;
      else if (erase_go)                   done_q <= 1'b0;
      else if (stat_wr && req_wdata[DONE_BIT]) done_q <= 1'b0;
      if (accept && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= read_mux;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  logic unused_rd;
  assign unused_rd = main_rd;
endmodule

// File: rtl/flashwin_target_chk.sv
module flashwin_target_chk #(
  parameter int ERASE_CYCLES = 1040
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic       req_space,
  input logic [7:0] req_offset,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [63:0] rsp_rdata,
  input logic       busy,
  input logic       done_q,
  input logic [2:0] err_q
);
  logic [15:0] run_cnt;
  logic        clr_hit;

  assign clr_hit = req_valid && req_ready && req_write && !req_space && (req_offset == 8'h70);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else        run_cnt <= busy ? run_cnt + 1'b1 : 16'h0;
  end

  // R13
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R13
  rd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid);

  // R10
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done_q);

  // R10
  erase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == 16'(ERASE_CYCLES)));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_hit |=> ((err_q & $past(err_q)) == $past(err_q)));
endmodule

bind flashwin_target flashwin_target_chk #(
  .ERASE_CYCLES(BLOCK_WORDS + ERASE_HOLD)
) chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .req_space(req_space),
  .req_offset(req_offset),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata),
  .busy(busy),
  .done_q(done_q),
  .err_q(err_q)
);

// File: tb/flashwin_target_test.sv
`timescale 1ns/1ps
module flashwin_target_test;
  localparam int NR = 2;
  localparam int RB = 8192;
  localparam int RWORDS = RB / 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_space = 0, req_wide = 0, rsp_ready = 1;
  logic [7:0] req_offset = 0;
  logic [63:0] req_wdata = 0;
  logic req_ready, rsp_valid;
  logic [63:0] rsp_rdata;

  always #2.5 clk = ~clk;

  flashwin_target uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_space(req_space), .req_wide(req_wide),
    .req_offset(req_offset), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] refm [NR*RWORDS];
  bit known [NR*RWORDS];
  int unsigned cur_reg = 0;
  logic [31:0] cur_addr = 0;
  bit cur_busy = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input bit sp, input bit wide, input logic [7:0] off,
                     input logic [63:0] wd, output logic [63:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_space = sp; req_wide = wide;
    req_offset = off; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    rd = wr ? 64'h0 : rsp_rdata;
  endtask

  task automatic wreg(input bit sp, input logic [7:0] off, input logic [63:0] d);
    logic [63:0] dummy;
    bus(1, sp, 0, off, d, dummy);
  endtask

  task automatic rreg(input bit sp, input logic [7:0] off, output logic [63:0] d);
    bus(0, sp, 0, off, 64'h0, d);
  endtask

  task automatic set_addr(input logic [31:0] a);
    wreg(0, 8'h40, {32'h0, a}); cur_addr = a;
  endtask

  task automatic set_reg(input int unsigned r);
    wreg(0, 8'h44, 64'(r)); cur_reg = r;
  endtask

  function automatic logic [2:0] exp_err(input int unsigned r, input logic [31:0] a,
                                         input bit wide, input bit bsy);
    logic [2:0] e;
    e = 3'b000;
    e[2] = (a[1:0] != 2'b00) || bsy;
    e[0] = (r >= NR) || (a >= RB) || (wide && a > RB - 8) || (!wide && a > RB - 4);
    e[1] = wide && (a[9:2] == 8'hFF);
    return e;
  endfunction

  task automatic trig(input bit wr, input bit wide, input logic [63:0] wd, input string tag);
    logic [2:0] ee;
    logic [63:0] rd;
    int w;
    ee = exp_err(cur_reg, cur_addr, wide, cur_busy);
    bus(wr, 0, wide, 8'h00, wd, rd);
    if (ee == 0) begin
      w = int'(cur_reg) * RWORDS + int'(cur_addr >> 2);
      if (wr) begin
        refm[w] = wd[31:0]; known[w] = 1;
        if (wide) begin refm[w+1] = wd[63:32]; known[w+1] = 1; end
      end else if (known[w] && (!wide || known[w+1])) begin
        check({tag, " data"}, rd, wide ? {refm[w+1], refm[w]} : {32'h0, refm[w]});
      end
    end else if (!wr) begin
      check({tag, " faulted read data"}, rd, 64'h0);
    end
    rreg(0, 8'h70, rd);
    check({tag, " error bits"}, rd, {61'h0, ee});
    if (ee != 0) begin
      rreg(0, 8'h74, rd);
      check("R8 fault address", rd, {32'h0, cur_addr});
      wreg(0, 8'h70, 64'h7);
    end
  endtask

  task automatic read_word(input int unsigned r, input logic [31:0] a, input logic [31:0] exp,
                           input string tag);
    logic [63:0] rd;
    set_reg(r); set_addr(a);
    bus(0, 0, 0, 8'h00, 64'h0, rd);
    check(tag, rd, {32'h0, exp});
  endtask

  task automatic wait_done(input string tag);
    logic [63:0] rd;
    int n;
    n = 0;
    rreg(1, 8'h00, rd);
    while (rd[23] == 1'b0 && n < 3000) begin
      rreg(1, 8'h00, rd); n++;
    end
    check(tag, 64'(rd[23]), 64'h1);
    cur_busy = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd, v1;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NR*RWORDS; i++) known[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 req_ready", 64'(req_ready), 64'h1);
    check("R1 rsp_valid", 64'(rsp_valid), 64'h0);
    rreg(0, 8'h44, rd); check("R1 region select", rd, 64'h0);
    rreg(0, 8'h70, rd); check("R1 error register", rd, 64'h0);
    rreg(1, 8'h00, rd); check("R1 done flag", rd, 64'h0);

    // R2 narrow write/read in region 1
    set_reg(1); set_addr(32'h10);
    trig(1, 0, 64'hDEAD_BEEF_A5A5_5A5A, "R2");
    trig(0, 0, 64'h0, "R2");
    set_reg(0); set_addr(32'h10);
    trig(1, 0, 64'h0000_0000_1234_5678, "R2");
    read_word(1, 32'h10, 32'hA5A5_5A5A, "R2 region isolation");

    // R3 wide accesses
    set_reg(0); set_addr(32'd1016);
    trig(1, 1, 64'h1122_3344_5566_7788, "R3");
    read_word(0, 32'd1016, 32'h5566_7788, "R3 low half");
    read_word(0, 32'd1020, 32'h1122_3344, "R3 high half");
    set_addr(32'h24);
    trig(1, 1, 64'hCAFE_0001_BEEF_0002, "R3");
    trig(0, 1, 64'h0, "R3");

    // R5 1 KiB line crossing
    set_addr(32'd1020);
    trig(1, 1, 64'hFFFF_0000_FFFF_0000, "R5");
    trig(0, 1, 64'h0, "R5");
    read_word(0, 32'd1020, 32'h1122_3344, "R5 array unchanged");

    // R4 bounds
    set_addr(32'd8192); trig(1, 0, 64'h1, "R4");
    set_addr(32'd8188); trig(1, 1, 64'h2, "R4");
    set_addr(32'd8184); trig(1, 1, 64'h0000_0003_0000_0004, "R4");
    trig(0, 1, 64'h0, "R4");
    set_reg(2); set_addr(32'h10); trig(0, 0, 64'h0, "R4");
    read_word(0, 32'h10, 32'h1234_5678, "R4 array unchanged");

    // R6 misaligned
    set_reg(0); set_addr(32'h13); trig(1, 0, 64'h9, "R6");
    read_word(0, 32'h10, 32'h1234_5678, "R6 array unchanged");

    // R7 sticky partial clear
    set_reg(0);
    set_addr(32'd9000); bus(1, 0, 0, 8'h00, 64'h0, rd);
    set_addr(32'h2); bus(1, 0, 0, 8'h00, 64'h0, rd);
    rreg(0, 8'h70, rd); check("R7 both bits", rd, 64'h5);
    rreg(0, 8'h74, rd); check("R8 last fault address", rd, 64'h2);
    wreg(0, 8'h70, 64'h1);
    rreg(0, 8'h70, rd); check("R7 partial clear", rd, 64'h4);
    wreg(0, 8'h70, 64'hF8);
    rreg(0, 8'h70, rd); check("R7 zeros and upper bits ignored", rd, 64'h4);
    wreg(0, 8'h70, 64'h4);
    rreg(0, 8'h70, rd); check("R7 full clear", rd, 64'h0);

    // R13 back-pressure
    set_reg(1);
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_space = 0; req_offset = 8'h44;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; v1 = rsp_rdata;
    repeat (3) @(negedge clk);
    check("R13 rsp_valid held", 64'(rsp_valid), 64'h1);
    check("R13 req_ready low", 64'(req_ready), 64'h0);
    check("R13 data held", rsp_rdata, v1);
    check("R13 data value", rsp_rdata, 64'h1);
    rsp_ready = 1;
    @(negedge clk);
    check("R13 response taken", 64'(rsp_valid), 64'h0);

    // random window traffic
    for (int i = 0; i < 300; i++) begin
      int unsigned sel;
      logic [31:0] a;
      sel = $urandom % 16;
      if (sel == 0) set_reg(2);
      else set_reg($urandom % 2);
      a = ($urandom % RB) & 32'hFFFF_FFFC;
      if (sel == 1) a = a | 32'h1;
      if (sel == 2) a = RB - 8 + 4 * ($urandom % 4);
      if (sel == 3) a = (a & 32'hFFFF_FC00) | 32'h3FC;
      set_addr(a);
      trig($urandom % 2, $urandom % 2, {$urandom, $urandom}, "R2 R3 random");
    end

    // R9 erase of block 1 in region 1
    set_reg(1);
    set_addr(32'h0FFC); trig(1, 0, 64'h0BAD_0001, "R2");
    set_addr(32'h1000); trig(1, 0, 64'h0BAD_0002, "R2");
    set_addr(32'h1FFC); trig(1, 0, 64'h0BAD_0003, "R2");
    set_addr(32'h0000); trig(1, 0, 64'h0BAD_0004, "R2");
    set_reg(0); set_addr(32'h1000); trig(1, 0, 64'h0BAD_0005, "R2");
    set_reg(1);
    set_addr(32'h1234);
    wreg(0, 8'h48, 64'h0100_0010);
    cur_busy = 1;
    rreg(1, 8'h00, rd); check("R10 done low while busy", rd, 64'h0);
    // R12 window write during erase is ignored
    set_addr(32'h0000);
    trig(1, 0, 64'h7777_7777, "R12");
    set_addr(32'h1234);
    wreg(0, 8'h48, 64'h0100_0010);
    rreg(0, 8'h70, rd); check("R12 erase while busy", rd, 64'h4);
    wreg(0, 8'h70, 64'h7);
    wait_done("R10 done raised");
    for (int k = 1024; k < 2048; k++) begin refm[RWORDS + k] = 32'hFFFF_FFFF; known[RWORDS + k] = 1; end
    read_word(1, 32'h1000, 32'hFFFF_FFFF, "R9 block start wiped");
    read_word(1, 32'h1FFC, 32'hFFFF_FFFF, "R9 block end wiped");
    read_word(1, 32'h0FFC, 32'h0BAD_0001, "R9 neighbour block kept");
    read_word(1, 32'h0000, 32'h0BAD_0004, "R12 busy write ignored");
    read_word(0, 32'h1000, 32'h0BAD_0005, "R9 other region kept");
    wreg(1, 8'h00, 64'h0);
    rreg(1, 8'h00, rd); check("R10 write without bit 23 keeps done", rd, 64'h80_0000);
    wreg(1, 8'h00, 64'h80_0000);
    rreg(1, 8'h00, rd); check("R10 done cleared", rd, 64'h0);

    // R11 rejected erase words
    set_addr(32'h0);
    wreg(0, 8'h48, 64'h0100_0080);
    rreg(0, 8'h70, rd); check("R11 unsupported size code", rd, 64'h4);
    wreg(0, 8'h70, 64'h7);
    set_reg(1); set_addr(32'h0); trig(0, 0, 64'h0, "R11 no erase started");
    set_addr(32'h0);
    wreg(0, 8'h48, 64'h0200_0010);
    rreg(0, 8'h70, rd); check("R11 bad erase region", rd, 64'h1);
    rreg(0, 8'h74, rd); check("R8 erase fault address", rd, 64'h0);
    wreg(0, 8'h70, 64'h7);
    set_addr(32'd8192);
    wreg(0, 8'h48, 64'h0000_0010);
    rreg(0, 8'h70, rd); check("R11 erase address out of range", rd, 64'h1);
    wreg(0, 8'h70, 64'h7);
    repeat (20) @(negedge clk);
    rreg(1, 8'h00, rd); check("R11 done stays low", rd, 64'h0);
    read_word(1, 32'h0000, 32'h0BAD_0004, "R11 array untouched");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule